// File: doc/BRIEF.md
# Serial Configuration Loader Master

This block loads a configuration bitstream into a target device through a one-bit serial port. It takes bytes from a ready/valid stream that marks its final byte. It also drives the target's active-low program line and generates the configuration clock. It watches two status lines from the target. The first is an active-low init line, which the target pulls low while it clears its memory and again when it finds an error. The second is a done line, which goes high once configuration has finished.

A pulse on `start` begins a load. The block pulls program low and waits for the target to pull init low. It then releases program and waits for the target to release init. After that it shifts each byte out, most significant bit first. Data changes only while the configuration clock is low. After the final byte it holds the data line high and keeps clocking until done rises. Each load ends with exactly one result flag: success, configuration error or timeout. That flag holds until the next start.

Top module: `cfg_serial_loader`

## Requirements
- R1: A `start` pulse while idle drives `prog_n` low from the next cycle until `init_n` is sampled low. If `init_n` stays high for TIMEOUT consecutive cycles, the load ends with `tmo` set.
- R2: In the cycle after `init_n` is sampled low, `prog_n` returns high. The block then waits for `init_n` to be sampled high. If `init_n` stays low for TIMEOUT cycles, `tmo` is set and no byte is taken from the stream.
- R3: Each byte is shifted out on `dout` in the order bit 7 down to bit 0.
- R4: Each bit takes three phases. First, `cclk` is low for SETTLE cycles and `dout` keeps its previous value. Next, `dout` shows the new bit and `cclk` stays low for SETTLE more cycles. Last, `cclk` is high for HALF cycles.
- R5: Before each byte is taken, the block tests the status lines. If `init_n` is low while `done` is low, the block sets `err`, takes no byte and returns to idle with `dout` high.
- R6: After the last byte, `dout` is held high and `cclk` toggles with a half period of HALF cycles, starting low. This continues until `done` is sampled high. `ok` is then set and the block returns to idle.
- R7: If `done` stays low for TIMEOUT cycles during the final clocking phase, `tmo` is set and the block returns to idle.
- R8: `start` clears all three flags `ok`, `err` and `tmo`. At most one of them is ever high, and each holds until the next accepted `start`.
- R9: While idle, `prog_n`, `cclk` and `dout` are high and `busy` is low. A `start` pulse while busy has no effect.
- R10: A byte is taken only in a cycle where both `s_valid` and `s_ready` are high. `s_ready` is high only while the block waits for a byte, and `cclk` stays high during such a wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a load |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Marks the final byte |
| s_ready | output | 1 | Block accepts a byte this cycle |
| init_n | input | 1 | Target status, low = clearing or error |
| done | input | 1 | Target configuration complete |
| prog_n | output | 1 | Active-low program request to target |
| cclk | output | 1 | Configuration clock |
| dout | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load finished with done |
| err | output | 1 | Last load stopped on a target error |
| tmo | output | 1 | Last load stopped on a timeout |

## Verification
Two situations are hard to reach from the ports: a target error that appears between bytes, and a timeout in the final clocking phase. Neither can happen unless the handshake has already succeeded and real data has moved. The bench therefore drives `init_n` and `done` from a small target model with adjustable settings. That model pulls `init_n` low again once a chosen number of bytes has been accepted, and it can be set never to raise `done`. A reference model in the bench follows every cycle. Through it, the bench checks that exactly one flag results and how many stream bytes were left unconsumed.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int SETTLE  = 4,
  parameter int HALF    = 4,
  parameter int TIMEOUT = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       init_n,
  input  logic       done,
  output logic       prog_n,
  output logic       cclk,
  output logic       dout,
  output logic       busy,
  output logic       ok,
  output logic       err,
  output logic       tmo
);
  localparam int TW   = $clog2(TIMEOUT + 1);
  localparam int PMAX = (SETTLE > HALF) ? SETTLE : HALF;
  localparam int CW   = $clog2(PMAX + 1);
  localparam logic [TW-1:0] T_END = TW'(TIMEOUT - 1);
  localparam logic [CW-1:0] S_END = CW'(SETTLE - 1);
  localparam logic [CW-1:0] H_END = CW'(HALF - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_REL, ST_FETCH, ST_LO, ST_SU, ST_HI, ST_FLO, ST_FHI
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          last_q, dout_q, ok_q, err_q, tmo_q;

  wire fault   = !init_n && !done;
  wire t_exp   = (tmr == T_END);
  wire in_fl   = (st == ST_FLO) || (st == ST_FHI);

  assign s_ready = (st == ST_FETCH) && !fault;
  assign prog_n  = (st != ST_ARM);
  assign cclk    = !((st == ST_LO) || (st == ST_SU) || (st == ST_FLO));
  assign dout    = dout_q;
  assign busy    = (st != ST_IDLE);
  assign ok      = ok_q;
  assign err     = err_q;
  assign tmo     = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tmr    <= '0;
      cnt    <= '0;
      sh     <= '0;
      bitn   <= '0;
      last_q <= 1'b0;
      dout_q <= 1'b1;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_ARM;
          tmr   <= '0;
          ok_q  <= 1'b0;
          err_q <= 1'b0;
          tmo_q <= 1'b0;
        end
        ST_ARM, ST_REL: begin
          if ((st == ST_ARM) ? !init_n : init_n) begin
            st  <= (st == ST_ARM) ? ST_REL : ST_FETCH;
            tmr <= '0;
          end else if (t_exp) begin
            tmo_q <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_FETCH: begin
          if (fault) begin
            err_q  <= 1'b1;
            dout_q <= 1'b1;
            st     <= ST_IDLE;
          end else if (s_valid) begin
            sh     <= s_data;
            last_q <= s_last;
            bitn   <= '0;
            cnt    <= '0;
            st     <= ST_LO;
          end
        end
        ST_LO: begin
          if (cnt == S_END) begin
            cnt    <= '0;
            dout_q <= sh[7];
            st     <= ST_SU;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SU: begin
          if (cnt == S_END) begin
            cnt <= '0;
            st  <= ST_HI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HI: begin
          if (cnt == H_END) begin
            cnt  <= '0;
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (bitn != 3'd7) begin
              st <= ST_LO;
            end else if (last_q) begin
              dout_q <= 1'b1;
              tmr    <= '0;
              st     <= ST_FLO;
            end else begin
              st <= ST_FETCH;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (in_fl && done) begin
            ok_q <= 1'b1;
            st   <= ST_IDLE;
          end else if (t_exp) begin
            tmo_q <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
            if (cnt == H_END) begin
              cnt <= '0;
              st  <= (st == ST_FLO) ? ST_FHI : ST_FLO;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic s_ready,
  input logic init_n,
  input logic done,
  input logic prog_n,
  input logic cclk,
  input logic dout,
  input logic busy,
  input logic ok,
  input logic err,
  input logic tmo
);
  assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, err, tmo}));

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({ok, err, tmo}));

  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && cclk && dout));

  assert_ready_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (cclk && prog_n && busy));

  assert_data_while_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cclk && $past(cclk)) |-> $stable(dout));

  assert_ok_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> $past(done));

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(!init_n && !done));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (.*);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;
  localparam int PERIOD = 10;
  localparam int SET = 2, HLF = 3, TO = 200;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] s_data = 0;
  logic s_valid = 0, s_last = 0, init_n = 1, done = 0;
  logic s_ready, prog_n, cclk, dout, busy, ok, err, tmo;

  cfg_serial_loader #(.SETTLE(SET), .HALF(HLF), .TIMEOUT(TO)) i_cfg_serial_loader (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // target knobs and state
  int a_dly = 3, r_dly = 4, done_edges = -1, err_byte = -1, gap = 0;
  int a_cnt = 0, r_cnt = 0, edges = 0, gap_cnt = 0;
  bit erring = 0;
  logic prev_cclk = 1;
  logic [7:0] txq[$];

  // reference model
  int m_ph = 0, m_tmr = 0, m_fc = 0, m_bytes = 0;
  logic m_prog = 1, m_cclk = 1, m_dout = 1, m_ok = 0, m_err = 0, m_tmo = 0, m_last = 0;
  logic [1:0] eq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_prog = 1; m_cclk = 1; m_dout = 1; m_ok = 0; m_err = 0; m_tmo = 0;
    end else begin
      case (m_ph)
        0: if (start) begin
          m_ph = 1; m_prog = 0; m_tmr = 0; m_ok = 0; m_err = 0; m_tmo = 0;
        end
        1, 2: begin
          if ((m_ph == 1) ? !init_n : init_n) begin
            m_ph = m_ph + 1; m_prog = 1; m_tmr = 0;
          end else if (m_tmr == TO - 1) begin
            m_tmo = 1; m_ph = 0; m_prog = 1;
          end else m_tmr++;
        end
        3: begin
          if (!init_n && !done) begin
            m_err = 1; m_ph = 0; m_dout = 1;
          end else if (s_valid) begin
            logic p;
            logic [1:0] e;
            p = m_dout;
            for (int b = 7; b >= 0; b--) begin
              for (int k = 0; k < SET; k++) eq.push_back({1'b0, p});
              for (int k = 0; k < SET; k++) eq.push_back({1'b0, s_data[b]});
              for (int k = 0; k < HLF; k++) eq.push_back({1'b1, s_data[b]});
              p = s_data[b];
            end
            m_last = s_last;
            e = eq.pop_front();
            m_cclk = e[1]; m_dout = e[0];
            m_ph = 4; m_bytes++;
            void'(txq.pop_front());
            gap_cnt = gap;
          end
        end
        4: begin
          if (eq.size() > 0) begin
            logic [1:0] e;
            e = eq.pop_front();
            m_cclk = e[1]; m_dout = e[0];
          end else if (m_last) begin
            m_ph = 5; m_dout = 1; m_cclk = 0; m_tmr = 0; m_fc = 0;
          end else m_ph = 3;
        end
        default: begin
          if (done) begin
            m_ok = 1; m_ph = 0; m_cclk = 1;
          end else if (m_tmr == TO - 1) begin
            m_tmo = 1; m_ph = 0; m_cclk = 1;
          end else begin
            m_tmr++; m_fc++;
            if (m_fc == HLF) begin m_fc = 0; m_cclk = !m_cclk; end
          end
        end
      endcase
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n) begin
      chk("R1 prog_n", prog_n, m_prog);
      chk("R4 cclk", cclk, m_cclk);
      chk("R3 dout", dout, m_dout);
      chk("R10 s_ready", s_ready, (m_ph == 3) && !(!init_n && !done));
      chk("R6 ok", ok, m_ok);
      chk("R5 err", err, m_err);
      chk("R7 tmo", tmo, m_tmo);
      chk("R9 busy", busy, m_ph != 0);
    end
  end

  // target device and stream source
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prog_n) begin
        a_cnt++;
        if (a_dly >= 0 && a_cnt >= a_dly) init_n = 0;
      end else if (!init_n && !erring) begin
        r_cnt++;
        if (r_dly >= 0 && r_cnt >= r_dly) init_n = 1;
      end
      if (err_byte >= 0 && m_bytes >= err_byte && prog_n && busy) begin
        init_n = 0; erring = 1;
      end
      if (cclk && !prev_cclk) edges++;
      prev_cclk = cclk;
      if (done_edges >= 0 && edges >= done_edges) done = 1;
      if (gap_cnt > 0) begin
        gap_cnt--; s_valid = 0;
      end else if (txq.size() > 0) begin
        s_valid = 1; s_data = txq[0]; s_last = (txq.size() == 1);
      end else s_valid = 0;
    end
  end

  task automatic run(int ad, int rd, int de, int eb, int gp);
    @(negedge clk); #1;
    a_dly = ad; r_dly = rd; done_edges = de; err_byte = eb; gap = gp;
    a_cnt = 0; r_cnt = 0; edges = 0; m_bytes = 0; erring = 0;
    init_n = 1; done = 0; prev_cclk = 1; gap_cnt = 0;
    start = 1;
    @(negedge clk); #1; start = 0;
    @(posedge clk);
    wait (m_ph == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start_later(int n);
    repeat (n) @(negedge clk);
    #1 start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset prog_n", prog_n, 1);
    chk("R9 reset cclk", cclk, 1);
    chk("R9 reset dout", dout, 1);
    chk("R8 reset flags", {ok, err, tmo}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // normal load, start pulsed again mid-load (R9: ignored)
    txq = '{8'hA5, 8'h3C, 8'h81};
    fork
      run(3, 4, 26, -1, 0);
      pulse_start_later(40);
    join
    chk("R6 ok after normal load", ok, 1);
    chk("R10 all bytes consumed", txq.size(), 0);

    // stalled stream
    txq = '{8'h00, 8'hFF};
    run(2, 1, 17, -1, 3);
    chk("R10 ok with stalls", ok, 1);

    // done arrives at the last data edge
    txq = '{8'h6E};
    run(1, 1, 8, -1, 0);
    chk("R6 ok on first flush cycle", ok, 1);

    // init never asserts
    txq = '{8'h12, 8'h34};
    run(-1, 1, 16, -1, 0);
    chk("R1 tmo init never active", tmo, 1);
    chk("R2 no byte taken", txq.size(), 2);
    txq.delete(); s_valid = 0;

    // init never releases
    txq = '{8'h12};
    run(2, -1, 8, -1, 0);
    chk("R2 tmo init never released", tmo, 1);
    chk("R2 no byte taken on release timeout", txq.size(), 1);
    txq.delete(); s_valid = 0;

    // error mid-stream after two bytes
    txq = '{8'hC3, 8'h5A, 8'h99, 8'h01};
    run(2, 2, -1, 2, 0);
    chk("R5 err mid-stream", err, 1);
    chk("R5 bytes left", txq.size(), 2);
    chk("R5 dout high after error", dout, 1);
    txq.delete(); s_valid = 0;

    // done never comes
    txq = '{8'hF0};
    run(1, 1, -1, -1, 0);
    chk("R7 tmo in flush", tmo, 1);
    chk("R8 ok clear on tmo", ok, 0);

    // recovery
    txq = '{8'h7E, 8'h18};
    run(2, 2, 18, -1, 1);
    chk("R8 flags cleared then ok", {ok, err, tmo}, 3'b100);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule